// File: doc/BRIEF.md
# Line Uniformity Statistics Engine

This block reduces one scan line of digitized pixel samples to three figures of merit: the line mean, the worst deviation of any single pixel from that mean, and that deviation expressed as a percentage of the mean. With the sensor illuminated uniformly, the percentage is the photo-response non-uniformity. With the sensor shielded, the mean is the average dark level and the deviation is the dark-signal non-uniformity.

Samples arrive as a stream. `sol_i` marks the first sample of a line and `last_i` marks the final one, each qualified by `valid_i`. During the stream the block keeps a running sum, count, minimum and maximum, so it makes only one pass over the data. After the last sample, one shared sequential divider produces the mean and then the percentage. A one-cycle `done_o` pulse then presents the results. A line whose sample count is not exactly the nominal pixel count is reported as an error and carries no results.

Top module: `line_uniformity_stats`

## Requirements
- R1: A line begins with a sample where `sol_i` and `valid_i` are both high. That sample is the first one counted. Every later `valid_i` sample is counted, and the sample with `last_i` and `valid_i` high ends the line.
- R2: For a line of exactly NUM_PIX samples, `mean_o` equals floor(sum of samples / NUM_PIX).
- R3: `dev_o` equals the larger of (largest sample − `mean_o`) and (`mean_o` − smallest sample).
- R4: `pct_o` equals floor(`dev_o` × 100 / `mean_o`). When `mean_o` is 0, `pct_o` is 0.
- R5: `done_o` is high for exactly one cycle, only after both quotients are ready. On a good line it comes with `res_valid_o`=1 and `err_o`=0. The outputs hold their values until the next `done_o`.
- R6: If the line ends with a count other than NUM_PIX, `done_o` pulses with `err_o`=1 and `res_valid_o`=0, and `mean_o`, `dev_o` and `pct_o` are all 0.
- R7: A `sol_i` in the middle of a line, or during a computation, throws away everything gathered so far. The results then reflect only the new line.
- R8: Samples, including one flagged with `last_i`, that arrive after a line has finished and before the next `sol_i` are ignored. They produce no `done_o` and leave the outputs unchanged.
- R9: After reset, `done_o`, `res_valid_o`, `err_o`, `mean_o`, `dev_o` and `pct_o` are all 0.
- R10: Cycles with `valid_i` low inside a line are not counted and do not affect the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sol_i | input | 1 | Start of line; marks the first sample and clears the statistics |
| valid_i | input | 1 | Sample qualifier |
| last_i | input | 1 | Marks the final sample of a line |
| pix_i | input | DATA_W | Pixel sample |
| done_o | output | 1 | One-cycle result strobe |
| res_valid_o | output | 1 | Results are valid |
| err_o | output | 1 | Line had the wrong sample count |
| mean_o | output | DATA_W | Line mean |
| dev_o | output | DATA_W | Largest absolute deviation from the mean |
| pct_o | output | DATA_W+7 | Deviation as a percentage of the mean |

## Verification
The block is driven with several kinds of line:
- A flat line with idle gaps shows that gaps are not counted.
- A line with one high spike and a line with one low dip show which side of the mean sets the deviation. The dip line also exercises a mean that floors below the dominant level.
- A ramp produces a mixed deviation.
- A dark line exercises the zero-mean percentage rule.
- A full-scale line checks that the accumulator holds the largest sum.

Lines one sample short and one sample long separate the count check from the arithmetic. A line restarted midway shows that earlier samples are discarded. Stray samples after a finished line, including a stray last flag, must give no strobe and must leave the outputs unchanged.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int unsigned PCT_SCALE = 100;
  localparam int unsigned SCALE_W   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_CHK,
    ST_MEAN,
    ST_DEV,
    ST_PCT
  } lus_state_e;
endpackage

// File: rtl/lus_accum.sv
module lus_accum #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned SUM_W  = DATA_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      sum_o <= '0;
      min_o <= '1;
      max_o <= '0;
    end else if (clear_i) begin
      cnt_o <= load_i ? CNT_W'(1) : '0;
      sum_o <= load_i ? SUM_W'(pix_i) : '0;
      min_o <= load_i ? pix_i : '1;
      max_o <= load_i ? pix_i : '0;
    end else if (load_i) begin
      // saturate so an overlong line can never wrap the sum
      if (cnt_o != CNT_SAT) begin
        cnt_o <= cnt_o + CNT_W'(1);
        sum_o <= sum_o + SUM_W'(pix_i);
      end
      if (pix_i < min_o) min_o <= pix_i;
      if (pix_i > max_o) max_o <= pix_i;
    end
  end

  // R3
  min_le_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |-> (min_o <= max_o));

  // R7
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !load_i) |=> (cnt_o == '0 && sum_o == '0));
endmodule

// File: rtl/lus_seq_div.sv
module lus_seq_div #(
  parameter int unsigned NUM_W = 26,
  parameter int unsigned DEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned STEP_W = $clog2(NUM_W + 1);

  logic [STEP_W-1:0] step_q;
  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W:0]    rem_sh;
  logic              fits;

  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_o <= 1'b0;
      end else if (start_i) begin
        den_q  <= den_i;
        rem_q  <= '0;
        step_q <= STEP_W'(NUM_W);
        if (den_i == '0) begin
          // zero divisor reports a zero quotient at once
          quo_q  <= '0;
          done_o <= 1'b1;
        end else begin
          quo_q  <= num_i;
          busy_o <= 1'b1;
        end
      end else if (busy_o) begin
        rem_q  <= fits ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        step_q <= step_q - STEP_W'(1);
        if (step_q == STEP_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;

  // R5
  div_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |-> !busy_o);

  // R5
  div_done_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/line_uniformity_stats.sv
module line_uniformity_stats
  import lus_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned NUM_PIX = 10680,
  localparam int unsigned PCT_W  = DATA_W + SCALE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sol_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              done_o,
  output logic              res_valid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] mean_o,
  output logic [DATA_W-1:0] dev_o,
  output logic [PCT_W-1:0]  pct_o
);
  localparam int unsigned CNT_W     = $clog2(NUM_PIX + 1);
  localparam int unsigned SUM_W     = DATA_W + CNT_W;
  localparam int unsigned DIV_NUM_W = (SUM_W > PCT_W) ? SUM_W : PCT_W;
  localparam int unsigned DEN_W     = (CNT_W > DATA_W) ? CNT_W : DATA_W;

  lus_state_e state_q;

  logic [CNT_W-1:0]     acc_cnt;
  logic [SUM_W-1:0]     acc_sum;
  logic [DATA_W-1:0]    acc_min, acc_max;
  logic                 acc_load;
  logic                 cnt_ok;
  logic [DATA_W-1:0]    mean_w, dev_w, dev_c, dev_hi, dev_lo;
  logic                 div_start, div_busy, div_done;
  logic [DIV_NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0]     div_den;

  assign acc_load = valid_i && (sol_i || state_q == ST_ACC);
  assign cnt_ok   = acc_cnt == CNT_W'(NUM_PIX);

  lus_accum #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .SUM_W (SUM_W)
  ) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(sol_i),
    .load_i (acc_load),
    .pix_i  (pix_i),
    .cnt_o  (acc_cnt),
    .sum_o  (acc_sum),
    .min_o  (acc_min),
    .max_o  (acc_max)
  );

  // one-pass worst deviation: whichever extreme lies farther from the mean
  assign dev_hi = acc_max - mean_w;
  assign dev_lo = mean_w - acc_min;
  assign dev_c  = (dev_hi > dev_lo) ? dev_hi : dev_lo;

  always_comb begin
    div_start = 1'b0;
    div_num   = DIV_NUM_W'(acc_sum);
    div_den   = DEN_W'(NUM_PIX);
    if (!sol_i) begin
      if (state_q == ST_CHK && cnt_ok) begin
        div_start = 1'b1;
      end else if (state_q == ST_DEV) begin
        div_start = 1'b1;
        div_num   = DIV_NUM_W'(dev_c) * DIV_NUM_W'(PCT_SCALE);
        div_den   = DEN_W'(mean_w);
      end
    end
  end

  lus_seq_div #(
    .NUM_W(DIV_NUM_W),
    .DEN_W(DEN_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(sol_i),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  generate
    if (DIV_NUM_W > PCT_W) begin : g_quo_spare
      logic quo_unused;
      assign quo_unused = ^div_quo[DIV_NUM_W-1:PCT_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mean_w      <= '0;
      dev_w       <= '0;
      done_o      <= 1'b0;
      res_valid_o <= 1'b0;
      err_o       <= 1'b0;
      mean_o      <= '0;
      dev_o       <= '0;
      pct_o       <= '0;
    end else begin
      done_o <= 1'b0;
      if (sol_i) begin
        state_q <= (valid_i && last_i) ? ST_CHK : ST_ACC;
      end else begin
        unique case (state_q)
          ST_ACC:  if (valid_i && last_i) state_q <= ST_CHK;
          ST_CHK: begin
            if (cnt_ok) begin
              state_q <= ST_MEAN;
            end else begin
              state_q     <= ST_IDLE;
              done_o      <= 1'b1;
              res_valid_o <= 1'b0;
              err_o       <= 1'b1;
              mean_o      <= '0;
              dev_o       <= '0;
              pct_o       <= '0;
            end
          end
          ST_MEAN: begin
            if (div_done) begin
              mean_w  <= div_quo[DATA_W-1:0];
              state_q <= ST_DEV;
            end
          end
          ST_DEV: begin
            dev_w   <= dev_c;
            state_q <= ST_PCT;
          end
          ST_PCT: begin
            if (div_done) begin
              state_q     <= ST_IDLE;
              done_o      <= 1'b1;
              res_valid_o <= 1'b1;
              err_o       <= 1'b0;
              mean_o      <= mean_w;
              dev_o       <= dev_w;
              pct_o       <= div_quo[PCT_W-1:0];
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mean_o, dev_o, pct_o}) |-> done_o);

  // R6
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !res_valid_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !sol_i) |=> !done_o);

  // R3
  mean_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV) |-> (mean_w >= acc_min && mean_w <= acc_max));

  // R5
  div_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_ACC) |-> !div_busy);
endmodule

// File: tb/line_uniformity_stats_tb.sv
module line_uniformity_stats_tb;
  localparam int DATA_W  = 12;
  localparam int NUM_PIX = 10680;
  localparam int PCT_W   = DATA_W + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sol = 1'b0, valid = 1'b0, last = 1'b0;
  logic [DATA_W-1:0] pix = '0;
  logic done, res_valid, err;
  logic [DATA_W-1:0] mean, dev;
  logic [PCT_W-1:0] pct;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  line_uniformity_stats #(.DATA_W(DATA_W), .NUM_PIX(NUM_PIX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sol_i(sol), .valid_i(valid), .last_i(last),
    .pix_i(pix), .done_o(done), .res_valid_o(res_valid), .err_o(err),
    .mean_o(mean), .dev_o(dev), .pct_o(pct)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix_of(input int kind, input int i);
    case (kind)
      0: return 1000;
      1: return (i == 5000) ? 2500 : 2000;
      2: return (i == NUM_PIX - 1) ? 100 : 3000;
      3: return (i * 37) % 4096;
      4: return 0;
      default: return 4095;
    endcase
  endfunction

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // R1 R10: drive one line; gaps insert an idle cycle with junk data
  task automatic run_line(input int kind, input int n, input bit gaps, input string req);
    longint sum = 0;
    int mn = 4095, mx = 0, v, e_mean, e_dev, e_pct;
    bit seen;
    for (int i = 0; i < n; i++) begin
      v = pix_of(kind, i);
      @(negedge clk);
      sol = (i == 0); valid = 1'b1; last = (i == n - 1); pix = DATA_W'(v);
      sum += v;
      if (v < mn) mn = v;
      if (v > mx) mx = v;
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        sol = 1'b0; valid = 1'b0; last = 1'b0; pix = 12'hABC;
      end
    end
    @(negedge clk);
    sol = 1'b0; valid = 1'b0; last = 1'b0;
    wait_done(seen);
    chk(seen, req, "done strobe", longint'(seen), 1);
    if (n == NUM_PIX) begin
      e_mean = int'(sum / NUM_PIX);
      e_dev  = ((mx - e_mean) > (e_mean - mn)) ? (mx - e_mean) : (e_mean - mn);
      e_pct  = (e_mean == 0) ? 0 : (e_dev * 100) / e_mean;
      chk(res_valid === 1'b1 && err === 1'b0, {req, " R5"}, "valid/err", {res_valid, err}, 2);
      chk(mean === DATA_W'(e_mean), {req, " R2"}, "mean", mean, e_mean);
      chk(dev === DATA_W'(e_dev), {req, " R3"}, "dev", dev, e_dev);
      chk(pct === PCT_W'(e_pct), {req, " R4"}, "pct", pct, e_pct);
    end else begin
      chk(res_valid === 1'b0 && err === 1'b1, "R6", "valid/err", {res_valid, err}, 1);
      chk(mean === '0 && dev === '0 && pct === '0, "R6", "zeroed results",
          longint'(mean) + dev + pct, 0);
    end
    @(negedge clk);
    chk(done === 1'b0, "R5", "done one cycle", done, 0);
  endtask

  task automatic test_reset();
    chk(done === 1'b0 && res_valid === 1'b0 && err === 1'b0, "R9", "flags",
        {done, res_valid, err}, 0);
    chk(mean === '0 && dev === '0 && pct === '0, "R9", "results",
        longint'(mean) + dev + pct, 0);
  endtask

  // R7: abandon a partial line, restart with a fresh one
  task automatic test_restart();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      sol = (i == 0); valid = 1'b1; last = 1'b0; pix = 12'd4000;
    end
    run_line(1, NUM_PIX, 1'b0, "R7");
  endtask

  // R8: stray samples after a finished line
  task automatic test_idle_ignore();
    logic [DATA_W-1:0] m0, d0;
    logic [PCT_W-1:0] p0;
    bit strobe = 1'b0, moved = 1'b0;
    m0 = mean; d0 = dev; p0 = pct;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sol = 1'b0; valid = 1'b1; last = (i == 29); pix = 12'd4095;
      if (done) strobe = 1'b1;
    end
    @(negedge clk);
    valid = 1'b0; last = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) strobe = 1'b1;
      if (mean !== m0 || dev !== d0 || pct !== p0) moved = 1'b1;
    end
    chk(!strobe, "R8", "no strobe when idle", strobe, 0);
    chk(!moved, "R8", "outputs unchanged", moved, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual no finish expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_line(0, NUM_PIX, 1'b1, "R10 flat");
    run_line(1, NUM_PIX, 1'b0, "R3 spike");
    run_line(2, NUM_PIX, 1'b0, "R3 dip");
    run_line(3, NUM_PIX, 1'b0, "R2 ramp");
    run_line(4, NUM_PIX, 1'b0, "R4 dark");
    run_line(5, NUM_PIX, 1'b0, "R2 fullscale");
    run_line(0, NUM_PIX - 1, 1'b0, "R6 short");
    run_line(0, NUM_PIX + 1, 1'b0, "R6 long");
    test_restart();
    test_idle_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule